// File: doc/BRIEF.md
# Bus Wake and Inactivity Supervisor

This block watches the sampled receive level of a CAN bus on behalf of a node that spends most of its life in a low-power state. It looks for a wake-up signature made of three bus phases: a dominant phase, then a recessive phase, then a second dominant phase. A phase counts only once the bus has held its level long enough to pass a glitch filter. The whole signature has to fit inside a deadline, and if it does the block raises a sticky wake flag for the host.

Two timers run beside the pattern detector. The silence timer restarts on every bus transition and signals when the bus has been idle for a long time. The inactivity timer starts at reset and again at every wake event. If the host neither acknowledges the wake nor asks for normal operation before that timer runs out, the block requests sleep on its own. Every time value is a parameter given in clock cycles, so a bench can use short values and a chip can use real durations.

Top module: `bus_wake_supervisor`

## Requirements
- R1: `bus_rx` is 1 for recessive and 0 for dominant. A phase qualifies on the sample that completes `FILT_CYC` consecutive samples at one level. A run of fewer samples is ignored: it neither advances nor breaks the signature.
- R2: The signature is a qualified dominant phase, then a qualified recessive phase, then a qualified dominant phase. `wake_flag` rises on the clock edge after the sample that qualifies the second dominant phase.
- R3: The sample that qualifies the last phase may come at most `WAKE_CYC` samples after the sample that qualified the first. Otherwise the attempt is dropped and detection waits for a new qualified dominant phase.
- R4: `wake_flag` is sticky and clears only on the edge after `wake_clear` is high. A wake event in the same cycle wins over the clear.
- R5: `bus_silent` is high once `SIL_CYC` consecutive samples have passed with no change of level. It drops on the edge of the first sample that differs from the previous one.
- R6: When the host takes no action, `sleep_req` rises on the (`INACT_CYC`+1)-th clock edge after the end of reset or after a wake event. A wake event clears `sleep_req` and restarts the count.
- R7: `wake_clear` or `normal_req` stops the inactivity timer and sets it back to zero. `sleep_req` does not rise again until a later wake event restarts the timer.
- R8: `normal_req` clears `sleep_req` on the next edge and keeps it low for as long as it is held.
- R9: While in reset and just after it, `wake_flag`, `bus_silent` and `sleep_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the bus is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive, 0 = dominant |
| wake_clear | input | 1 | Host acknowledge; clears the wake flag and stops the inactivity timer |
| normal_req | input | 1 | Host request for normal mode |
| wake_flag | output | 1 | Sticky wake-up detected indication |
| bus_silent | output | 1 | No bus transition for the silence time |
| sleep_req | output | 1 | Request to enter sleep after host inactivity |

## Verification
The hardest case to reach is a signature whose two dominant phases each qualify, but whose recessive phase between them is split by a sub-filter glitch. The glitch must leave the detector where it was rather than resetting it. The bench gets there by driving a dominant run, a recessive run one sample short of the filter, and another dominant run, and it confirms that no wake happens. It then finishes with a full recessive and dominant pair and expects the wake. A second awkward case is the deadline, which is reached by stretching the recessive phase past `WAKE_CYC`. The inactivity behaviour is reached by letting short parameterised timers run out between host actions.

// File: rtl/bws_pkg.sv
package bws_pkg;

    localparam logic LVL_DOM = 1'b0;
    localparam logic LVL_REC = 1'b1;

    typedef enum logic [1:0] {
        PAT_IDLE     = 2'd0,
        PAT_SEEN_DOM = 2'd1,
        PAT_SEEN_REC = 2'd2
    } pat_state_e;

    typedef struct packed {
        logic pulse;
        logic level;
    } phase_evt_t;

    function automatic logic is_qual(input phase_evt_t e, input logic lvl);
        return e.pulse && (e.level == lvl);
    endfunction

endpackage

// File: rtl/bws_phase_filter.sv
module bws_phase_filter
    import bws_pkg::*;
#(
    parameter int unsigned FILT_CYC = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_rx,
    output logic       edge_o,
    output phase_evt_t evt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] FLIM = CW'(FILT_CYC);

    logic          rx_s;
    logic [CW-1:0] run_cnt;
    logic [CW-1:0] run_nxt;

    assign edge_o = (bus_rx != rx_s);

    always_comb begin
        if (edge_o)
            run_nxt = CW'(1);
        else if (run_cnt != FLIM)
            run_nxt = run_cnt + CW'(1);
        else
            run_nxt = run_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_s    <= LVL_REC;
            run_cnt <= '0;
            evt_o   <= '{pulse: 1'b0, level: LVL_REC};
        end else begin
            rx_s        <= bus_rx;
            run_cnt     <= run_nxt;
            evt_o.pulse <= (run_nxt == FLIM) && (edge_o || (run_cnt != FLIM));
            evt_o.level <= bus_rx;
        end
    end

    AST_SINGLE_QUAL: assert property (@(posedge clk) disable iff (rst)
        (evt_o.pulse && (FILT_CYC > 1)) |=> !evt_o.pulse); // R1

endmodule

// File: rtl/bws_timer.sv
module bws_timer #(
    parameter longint unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && (cnt != LIM))
            cnt <= cnt + CW'(1);
    end

    assign expired = (cnt == LIM);

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        restart |=> !expired); // R5

endmodule

// File: rtl/bws_pattern_det.sv
module bws_pattern_det
    import bws_pkg::*;
#(
    parameter longint unsigned WAKE_CYC = 150000
) (
    input  logic       clk,
    input  logic       rst,
    input  phase_evt_t evt,
    output logic       wake_evt_o
);
    localparam int CW = $clog2(WAKE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYC - 1);

    pat_state_e    state, state_nxt;
    logic [CW-1:0] dl_cnt, dl_nxt;
    logic          expire;

    assign expire = (state != PAT_IDLE) && (dl_cnt == LAST);

    always_comb begin
        state_nxt  = state;
        dl_nxt     = dl_cnt + CW'(1);
        wake_evt_o = 1'b0;
        unique case (state)
            PAT_IDLE: begin
                dl_nxt = '0;
                if (is_qual(evt, LVL_DOM))
                    state_nxt = PAT_SEEN_DOM;
            end
            PAT_SEEN_DOM: begin
                if (expire)
                    state_nxt = PAT_IDLE;
                else if (is_qual(evt, LVL_REC))
                    state_nxt = PAT_SEEN_REC;
            end
            PAT_SEEN_REC: begin
                if (is_qual(evt, LVL_DOM)) begin
                    wake_evt_o = 1'b1;
                    state_nxt  = PAT_IDLE;
                end else if (expire) begin
                    state_nxt = PAT_IDLE;
                end
            end
            default: state_nxt = PAT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= PAT_IDLE;
            dl_cnt <= '0;
        end else begin
            state  <= state_nxt;
            dl_cnt <= dl_nxt;
        end
    end

    AST_DEADLINE_DROP: assert property (@(posedge clk) disable iff (rst)
        (expire && !wake_evt_o) |=> (state == PAT_IDLE)); // R3
    AST_WAKE_NEEDS_REC: assert property (@(posedge clk) disable iff (rst)
        (state == PAT_IDLE) |-> !wake_evt_o); // R2

endmodule

// File: rtl/bus_wake_supervisor.sv
module bus_wake_supervisor
    import bws_pkg::*;
#(
    parameter int unsigned     FILT_CYC  = 100,
    parameter longint unsigned WAKE_CYC  = 150000,
    parameter longint unsigned SIL_CYC   = 100000000,
    parameter longint unsigned INACT_CYC = 64'd24000000000
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_rx,
    input  logic wake_clear,
    input  logic normal_req,
    output logic wake_flag,
    output logic bus_silent,
    output logic sleep_req
);
    logic       bus_edge;
    phase_evt_t phase_evt;
    logic       wake_evt;
    logic       ina_run;
    logic       ina_expired;
    logic       ina_restart;

    bws_phase_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk    (clk),
        .rst    (rst),
        .bus_rx (bus_rx),
        .edge_o (bus_edge),
        .evt_o  (phase_evt)
    );

    bws_pattern_det #(.WAKE_CYC(WAKE_CYC)) u_pattern (
        .clk        (clk),
        .rst        (rst),
        .evt        (phase_evt),
        .wake_evt_o (wake_evt)
    );

    bws_timer #(.LIMIT(SIL_CYC)) u_silence (
        .clk     (clk),
        .rst     (rst),
        .restart (bus_edge),
        .run     (1'b1),
        .expired (bus_silent)
    );

    assign ina_restart = normal_req | wake_evt | wake_clear;

    bws_timer #(.LIMIT(INACT_CYC)) u_inact (
        .clk     (clk),
        .rst     (rst),
        .restart (ina_restart),
        .run     (ina_run),
        .expired (ina_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_flag <= 1'b0;
            ina_run   <= 1'b1;
            sleep_req <= 1'b0;
        end else begin
            if (wake_evt)
                wake_flag <= 1'b1;
            else if (wake_clear)
                wake_flag <= 1'b0;

            if (normal_req) begin
                ina_run   <= 1'b0;
                sleep_req <= 1'b0;
            end else if (wake_evt) begin
                ina_run   <= 1'b1;
                sleep_req <= 1'b0;
            end else if (wake_clear) begin
                ina_run   <= 1'b0;
            end else if (ina_run && ina_expired) begin
                ina_run   <= 1'b0;
                sleep_req <= 1'b1;
            end
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wake_flag && !wake_clear) |=> wake_flag); // R4
    AST_FLAG_DROP: assert property (@(posedge clk) disable iff (rst)
        (wake_clear && !wake_evt) |=> !wake_flag); // R4
    AST_NORMAL_BLOCKS_SLEEP: assert property (@(posedge clk) disable iff (rst)
        normal_req |=> !sleep_req); // R8
    AST_SLEEP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(sleep_req) |-> (!$past(normal_req) && !$past(wake_clear))); // R7

endmodule

// File: tb/bus_wake_supervisor_bench.sv
module bus_wake_supervisor_bench;

    localparam int FILT  = 4;
    localparam int WAKE  = 60;
    localparam int SIL   = 50;
    localparam int INACT = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_rx = 1'b1;
    logic wake_clear = 1'b0;
    logic normal_req = 1'b0;
    logic wake_flag, bus_silent, sleep_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bus_wake_supervisor #(
        .FILT_CYC (FILT),
        .WAKE_CYC (64'(WAKE)),
        .SIL_CYC  (64'(SIL)),
        .INACT_CYC(64'(INACT))
    ) u_bus_wake_supervisor (
        .clk(clk), .rst(rst), .bus_rx(bus_rx), .wake_clear(wake_clear),
        .normal_req(normal_req), .wake_flag(wake_flag),
        .bus_silent(bus_silent), .sleep_req(sleep_req)
    );

    // Behavioural reference model, advanced on each sampling edge
    int  edge_no = 0;
    int  prev_lvl = 1;
    int  run_len = 0;
    int  quiet_len = 0;
    int  pend_q[$];
    int  stage = 0;
    int  t_first = 0;
    int  ina_elapsed = 0;
    bit  ina_on = 1;
    bit  exp_flag = 0, exp_silent = 0, exp_sleep = 0;

    always @(posedge clk) begin
        if (rst) begin
            prev_lvl = 1; run_len = 0; quiet_len = 0; pend_q.delete();
            stage = 0; edge_no = 0; ina_elapsed = 0; ina_on = 1;
            exp_flag = 0; exp_silent = 0; exp_sleep = 0;
        end else begin
            int  s;
            bit  trans, wake, got;
            int  lvl;
            edge_no++;
            s = int'(bus_rx);
            trans = (s != prev_lvl);
            prev_lvl = s;
            // phase decision from the previous sample
            got = (pend_q.size() > 0);
            lvl = got ? pend_q.pop_front() : -1;
            wake = 0;
            if (stage == 2 && got && lvl == 0 && edge_no - t_first <= WAKE) begin
                wake = 1; stage = 0;
            end else if (stage != 0 && edge_no - t_first >= WAKE) begin
                stage = 0;
            end else if (stage == 0 && got && lvl == 0) begin
                stage = 1; t_first = edge_no;
            end else if (stage == 1 && got && lvl == 1) begin
                stage = 2;
            end
            // glitch filter on this sample
            run_len = trans ? 1 : run_len + 1;
            if (run_len == FILT) pend_q.push_back(s);
            // flag
            if (wake) exp_flag = 1;
            else if (wake_clear) exp_flag = 0;
            // silence
            quiet_len = trans ? 0 : quiet_len + 1;
            exp_silent = (quiet_len >= SIL);
            // inactivity
            if (normal_req) begin
                ina_on = 0; ina_elapsed = 0; exp_sleep = 0;
            end else if (wake) begin
                ina_on = 1; ina_elapsed = 0; exp_sleep = 0;
            end else if (wake_clear) begin
                ina_on = 0; ina_elapsed = 0;
            end else if (ina_on) begin
                if (ina_elapsed == INACT) begin
                    exp_sleep = 1; ina_on = 0;
                end else begin
                    ina_elapsed++;
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (wake_flag !== exp_flag) begin
                errors++;
                $display("FAIL R2 wake_flag at edge %0d: got %b exp %b", edge_no, wake_flag, exp_flag);
            end
            checks++;
            if (bus_silent !== exp_silent) begin
                errors++;
                $display("FAIL R5 bus_silent at edge %0d: got %b exp %b", edge_no, bus_silent, exp_silent);
            end
            checks++;
            if (sleep_req !== exp_sleep) begin
                errors++;
                $display("FAIL R6 sleep_req at edge %0d: got %b exp %b", edge_no, sleep_req, exp_sleep);
            end
        end
    end

    task automatic phase(input logic lvl, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_rx = lvl;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clear();
        @(negedge clk); wake_clear = 1'b1;
        @(negedge clk); wake_clear = 1'b0;
    endtask

    task automatic expect_bit(input string tag, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    task automatic full_wake();
        phase(1'b0, 6); phase(1'b1, 6); phase(1'b0, 6); phase(1'b1, 3);
    endtask

    initial begin
        idle(3);
        expect_bit("R9 wake_flag in reset", wake_flag, 1'b0);
        expect_bit("R9 sleep_req in reset", sleep_req, 1'b0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        expect_bit("R9 bus_silent after reset", bus_silent, 1'b0);

        // R2: plain signature
        full_wake();
        expect_bit("R2 wake after signature", wake_flag, 1'b1);
        idle(10);
        expect_bit("R4 flag sticky", wake_flag, 1'b1);
        pulse_clear();
        expect_bit("R4 flag cleared", wake_flag, 1'b0);

        // R1: recessive run one short of the filter is ignored
        phase(1'b0, 6); phase(1'b1, FILT - 1); phase(1'b0, 6); phase(1'b1, 2);
        expect_bit("R1 short phase no wake", wake_flag, 1'b0);
        phase(1'b1, 4); phase(1'b0, 6); phase(1'b1, 2);
        expect_bit("R1 signature completes after glitch", wake_flag, 1'b1);
        pulse_clear();

        // R3: recessive phase past the deadline
        phase(1'b0, 6); phase(1'b1, WAKE + 10); phase(1'b0, 6); phase(1'b1, 2);
        expect_bit("R3 late signature dropped", wake_flag, 1'b0);
        phase(1'b1, 4); phase(1'b0, 6); phase(1'b1, 2);
        expect_bit("R3 fresh signature accepted", wake_flag, 1'b1);
        pulse_clear();

        // R5: silence and restart
        phase(1'b1, SIL + 5);
        expect_bit("R5 silence flagged", bus_silent, 1'b1);
        phase(1'b0, 1);
        @(negedge clk);
        expect_bit("R5 silence dropped on edge", bus_silent, 1'b0);
        phase(1'b1, 2);

        // R6: no host action after a wake leads to sleep
        full_wake();
        idle(INACT + 10);
        expect_bit("R6 sleep after inactivity", sleep_req, 1'b1);

        // R8: normal request
        @(negedge clk); normal_req = 1'b1;
        idle(5);
        expect_bit("R8 sleep low in normal", sleep_req, 1'b0);
        @(negedge clk); normal_req = 1'b0;
        idle(INACT + 50);
        expect_bit("R7 timer stopped by normal", sleep_req, 1'b0);

        // R7: clear stops the timer
        full_wake();
        idle(20);
        pulse_clear();
        idle(INACT + 50);
        expect_bit("R7 timer stopped by clear", sleep_req, 1'b0);

        // R6: wake clears a pending sleep and restarts
        full_wake();
        idle(INACT + 10);
        expect_bit("R6 sleep again", sleep_req, 1'b1);
        full_wake();
        expect_bit("R6 wake clears sleep", sleep_req, 1'b0);
        idle(5);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL all: watchdog expired, got hang exp completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule